// File: doc/BRIEF.md
# Interrupt Request Status Register

This block holds the pending state of every hardware interrupt source that an interrupt controller sees, and presents it as one read-only 16-bit status word. Five internal sources (a timer, two DMA channels and two serial ports) set sticky request bits. A bit stays set until the controller acknowledges that source. The five external interrupt pins have no latch. After a two-flop synchronizer, their bits show the live pin level, so an external device keeps its pin high until its handler tells it to let go.

Each serial port's request is the OR of its seven status flags, qualified by that port's interrupt enable. The controller clears a latched source by pulsing the acknowledge input for one cycle with a 3-bit select that names the source. Software samples the word through a registered read port.

Top module: `intr_pend_status`

## Requirements
- R1: The status word has this layout. Bit 0 is the timer. Bit 2 is DMA channel 0 (external 5). Bit 3 is DMA channel 1 (external 6). Bits 8 down to 4 carry external pins 4 down to 0. Bit 9 is serial port 1. Bit 10 is serial port 0. Bits 15 to 11 and bit 1 always read 0.
- R2: A one-cycle timer strobe sets bit 0. The bit stays set, with no further strobes, until the timer is acknowledged.
- R3: A strobe on dmaReq[0] sets bit 2 and a strobe on dmaReq[1] sets bit 3. Both bits are sticky in the same way as the timer bit.
- R4: An acknowledge (ackValid high for one cycle) clears only the source named by ackSel: 0 timer, 1 DMA0, 2 DMA1, 3 serial port 1, 4 serial port 0.
- R5: An acknowledge with ackSel 5, 6 or 7 changes no bit.
- R6: When a source's request strobe or set condition is present in the same cycle as its acknowledge, the bit stays set.
- R7: A serial port latches its request when its enable is high and any of its seven flags is high. The flags are bit 0 transmit holding empty, bit 1 receive data ready, bits 2 and 3 the two break flags, bit 4 framing error, bit 5 parity error and bit 6 overrun. The bit stays set after the flags drop.
- R8: A serial port bit reads 0 while that port's enable is low, whatever its flags hold. Flags seen while the port is disabled are not latched. A bit latched earlier shows again once the port is enabled again.
- R9: Each external pin bit follows its pin through two synchronizer flops and has no latch: it returns to 0 when the pin falls.
- R10: A cycle with rdEn high loads the current status word into rdData at the next clock edge. rdData holds its value while rdEn is low.
- R11: While rstN is low, all request bits and rdData are cleared. The first read after reset returns 0 when no source is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tmrReq | input | 1 | Timer request strobe |
| dmaReq | input | 2 | DMA channel request strobes, index = channel |
| ser0Flags | input | 7 | Serial port 0 status flags (order in R7) |
| ser0En | input | 1 | Serial port 0 interrupt enable |
| ser1Flags | input | 7 | Serial port 1 status flags (order in R7) |
| ser1En | input | 1 | Serial port 1 interrupt enable |
| extPin | input | 5 | Asynchronous external interrupt pins 4..0 |
| ackValid | input | 1 | One-cycle acknowledge pulse |
| ackSel | input | 3 | Source select for the acknowledge (codes in R4) |
| rdEn | input | 1 | Read strobe for the status word |
| rdData | output | 16 | Registered status word |

## Verification
A sticky bit that loses its state or clears on the wrong select shows up in the next read of rdData. That is one edge after the read strobe, with no other delay in the path. A fault in the synchronizer depth shows as an external bit that appears one read early or late compared with the two-edge latency, or that stays set after its pin falls. A fault in the serial gating shows as a bit 9 or 10 that appears while the port's enable is low, or that is missing after the port is enabled again.

// File: rtl/intr_pend_pkg.sv
package intr_pend_pkg;
  localparam int REG_W   = 16;
  localparam int NUM_SRC = 5;
  localparam int SEL_W   = 3;

  // internal source index, equal to the acknowledge select code
  localparam int SRC_TMR  = 0;
  localparam int SRC_DMA0 = 1;
  localparam int SRC_DMA1 = 2;
  localparam int SRC_SER1 = 3;
  localparam int SRC_SER0 = 4;

  // bit positions in the status word
  localparam int BIT_TMR    = 0;
  localparam int BIT_DMA0   = 2;
  localparam int BIT_DMA1   = 3;
  localparam int BIT_EXT_LO = 4;
  localparam int BIT_SER1   = 9;
  localparam int BIT_SER0   = 10;

  localparam logic [REG_W-1:0] RES_MASK = 16'hF802;

  typedef struct packed {
    logic [NUM_SRC-1:0] clr;
    logic               capture;
  } ctrlStrobes_t;
endpackage

// File: rtl/intr_pend_ctrl.sv
module intr_pend_ctrl
  import intr_pend_pkg::*;
(
  input  logic             ackValid,
  input  logic [SEL_W-1:0] ackSel,
  input  logic             rdEn,
  output ctrlStrobes_t     strobes
);
  always_comb begin
    strobes.capture = rdEn;
    for (int i = 0; i < NUM_SRC; i++) begin
      strobes.clr[i] = ackValid && (ackSel == SEL_W'(i));
    end
  end
endmodule

// File: rtl/intr_pend_datapath.sv
module intr_pend_datapath
  import intr_pend_pkg::*;
#(
  parameter int EXT_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int SER_FLAG_W  = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tmrReq,
  input  logic [1:0]            dmaReq,
  input  logic [SER_FLAG_W-1:0] ser0Flags,
  input  logic                  ser0En,
  input  logic [SER_FLAG_W-1:0] ser1Flags,
  input  logic                  ser1En,
  input  logic [EXT_W-1:0]      extPin,
  input  ctrlStrobes_t          strobes,
  output logic [REG_W-1:0]      statusWord,
  output logic [REG_W-1:0]      rdData
);
  logic [NUM_SRC-1:0] srcSet;
  logic [NUM_SRC-1:0] pending;
  logic [EXT_W-1:0]   syncQ [SYNC_STAGES];

  always_comb begin
    srcSet[SRC_TMR]  = tmrReq;
    srcSet[SRC_DMA0] = dmaReq[0];
    srcSet[SRC_DMA1] = dmaReq[1];
    srcSet[SRC_SER1] = ser1En && (|ser1Flags);
    srcSet[SRC_SER0] = ser0En && (|ser0Flags);
  end

  // sticky request latches; a set wins over a clear in the same cycle
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN)                pending[g] <= 1'b0;
      else if (srcSet[g])       pending[g] <= 1'b1;
      else if (strobes.clr[g])  pending[g] <= 1'b0;
    end
  end

  // pin synchronizer chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN)       syncQ[s] <= '0;
      else if (s == 0) syncQ[s] <= extPin;
      else             syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[BIT_TMR]  = pending[SRC_TMR];
    statusWord[BIT_DMA0] = pending[SRC_DMA0];
    statusWord[BIT_DMA1] = pending[SRC_DMA1];
    statusWord[BIT_EXT_LO +: EXT_W] = syncQ[SYNC_STAGES-1];
    statusWord[BIT_SER1] = pending[SRC_SER1] && ser1En;
    statusWord[BIT_SER0] = pending[SRC_SER0] && ser0En;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                rdData <= '0;
    else if (strobes.capture) rdData <= statusWord;
  end
endmodule

// File: rtl/intr_pend_status.sv
module intr_pend_status
  import intr_pend_pkg::*;
#(
  parameter int EXT_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int SER_FLAG_W  = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tmrReq,
  input  logic [1:0]            dmaReq,
  input  logic [SER_FLAG_W-1:0] ser0Flags,
  input  logic                  ser0En,
  input  logic [SER_FLAG_W-1:0] ser1Flags,
  input  logic                  ser1En,
  input  logic [EXT_W-1:0]      extPin,
  input  logic                  ackValid,
  input  logic [SEL_W-1:0]      ackSel,
  input  logic                  rdEn,
  output logic [REG_W-1:0]      rdData
);
  ctrlStrobes_t     strobes;
  logic [REG_W-1:0] statusWord;

  intr_pend_ctrl u_ctrl (
    .ackValid (ackValid),
    .ackSel   (ackSel),
    .rdEn     (rdEn),
    .strobes  (strobes)
  );

  intr_pend_datapath #(
    .EXT_W       (EXT_W),
    .SYNC_STAGES (SYNC_STAGES),
    .SER_FLAG_W  (SER_FLAG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tmrReq     (tmrReq),
    .dmaReq     (dmaReq),
    .ser0Flags  (ser0Flags),
    .ser0En     (ser0En),
    .ser1Flags  (ser1Flags),
    .ser1En     (ser1En),
    .extPin     (extPin),
    .strobes    (strobes),
    .statusWord (statusWord),
    .rdData     (rdData)
  );
endmodule

// File: rtl/intr_pend_status_chk.sv
module intr_pend_status_chk
  import intr_pend_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             tmrReq,
  input logic [1:0]       dmaReq,
  input logic             ser0En,
  input logic             ackValid,
  input logic [SEL_W-1:0] ackSel,
  input logic             rdEn,
  input logic [REG_W-1:0] rdData,
  input logic [REG_W-1:0] statusWord
);
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & RES_MASK) == '0);

  p_tmr_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    tmrReq |=> statusWord[BIT_TMR]);

  p_tmr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[BIT_TMR] && !(ackValid && ackSel == 3'd0) |=> statusWord[BIT_TMR]);

  p_dma0_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq[0] |=> statusWord[BIT_DMA0]);

  p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    ackValid && ackSel == 3'd1 && !dmaReq[0] |=> !statusWord[BIT_DMA0]);

  p_bad_sel_r5: assert property (@(posedge clk) disable iff (!rstN)
    ackValid && ackSel > 3'd4 && statusWord[BIT_DMA1] |=> statusWord[BIT_DMA1]);

  p_race_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    ackValid && ackSel == 3'd0 && tmrReq |=> statusWord[BIT_TMR]);

  p_ser_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ser0En |-> !statusWord[BIT_SER0]);

  p_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdData == $past(statusWord));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
endmodule

bind intr_pend_status intr_pend_status_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tmrReq     (tmrReq),
  .dmaReq     (dmaReq),
  .ser0En     (ser0En),
  .ackValid   (ackValid),
  .ackSel     (ackSel),
  .rdEn       (rdEn),
  .rdData     (rdData),
  .statusWord (statusWord)
);

// File: tb/test_intr_pend_status.sv
`timescale 1ns/1ps
module test_intr_pend_status;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tmrReq = 1'b0;
  logic [1:0]  dmaReq = '0;
  logic [6:0]  ser0Flags = '0;
  logic        ser0En = 1'b0;
  logic [6:0]  ser1Flags = '0;
  logic        ser1En = 1'b0;
  logic [4:0]  extPin = '0;
  logic        ackValid = 1'b0;
  logic [2:0]  ackSel = '0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intr_pend_status i_intr_pend_status (
    .clk(clk), .rstN(rstN), .tmrReq(tmrReq), .dmaReq(dmaReq),
    .ser0Flags(ser0Flags), .ser0En(ser0En), .ser1Flags(ser1Flags), .ser1En(ser1En),
    .extPin(extPin), .ackValid(ackValid), .ackSel(ackSel), .rdEn(rdEn), .rdData(rdData)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic readReg(output logic [15:0] val);
    @(negedge clk); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
    val = rdData;
  endtask

  task automatic ack(input logic [2:0] sel);
    @(negedge clk); ackValid = 1'b1; ackSel = sel;
    @(negedge clk); ackValid = 1'b0;
  endtask

  task automatic tReset();
    logic [15:0] v;
    readReg(v);
    chk("R11 reset read", v, 16'h0000);
    chk("R1 reserved zero", v & 16'hF802, 16'h0000);
  endtask

  task automatic tTimer();
    logic [15:0] v;
    @(negedge clk); tmrReq = 1'b1;
    @(negedge clk); tmrReq = 1'b0;
    readReg(v);
    chk("R2 timer set", v, 16'h0001);
    repeat (4) @(negedge clk);
    readReg(v);
    chk("R2 timer sticky", v, 16'h0001);
  endtask

  task automatic tDmaAck();
    logic [15:0] v;
    @(negedge clk); dmaReq = 2'b11;
    @(negedge clk); dmaReq = 2'b00;
    readReg(v);
    chk("R3 dma bits", v, 16'h000D);
    ack(3'd1);
    readReg(v);
    chk("R4 ack dma0 only", v, 16'h0009);
    ack(3'd2);
    readReg(v);
    chk("R4 ack dma1 only", v, 16'h0001);
    ack(3'd0);
    readReg(v);
    chk("R4 ack timer", v, 16'h0000);
  endtask

  task automatic tBadSel();
    logic [15:0] v;
    @(negedge clk); tmrReq = 1'b1; dmaReq = 2'b11;
    @(negedge clk); tmrReq = 1'b0; dmaReq = 2'b00;
    for (int s = 5; s < 8; s++) ack(3'(s));
    readReg(v);
    chk("R5 unused selects ignored", v, 16'h000D);
    ack(3'd0); ack(3'd1); ack(3'd2);
    readReg(v);
    chk("R4 all cleared", v, 16'h0000);
  endtask

  task automatic tRace();
    logic [15:0] v;
    @(negedge clk); tmrReq = 1'b1; ackValid = 1'b1; ackSel = 3'd0;
    @(negedge clk); tmrReq = 1'b0; ackValid = 1'b0;
    readReg(v);
    chk("R6 strobe wins over ack", v, 16'h0001);
    ack(3'd0);
    readReg(v);
    chk("R6 later ack clears", v, 16'h0000);
  endtask

  task automatic tSerial();
    logic [15:0] v;
    ser0En = 1'b1;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk); ser0Flags = 7'(1 << k);
      @(negedge clk); ser0Flags = '0;
      readReg(v);
      chk($sformatf("R7 serial0 flag %0d", k), v, 16'h0400);
      ack(3'd4);
      readReg(v);
      chk("R4 serial0 ack", v, 16'h0000);
    end
    ser1En = 1'b1;
    @(negedge clk); ser1Flags = 7'h40;
    @(negedge clk); ser1Flags = '0;
    readReg(v);
    chk("R7 serial1 overrun", v, 16'h0200);
    ack(3'd3);
    readReg(v);
    chk("R4 serial1 ack", v, 16'h0000);
  endtask

  task automatic tSerGate();
    logic [15:0] v;
    ser1En = 1'b0;
    @(negedge clk); ser1Flags = 7'h7F;
    readReg(v);
    chk("R8 disabled reads zero", v, 16'h0000);
    @(negedge clk); ser1Flags = '0;
    ser1En = 1'b1;
    readReg(v);
    chk("R8 not latched while disabled", v, 16'h0000);
    @(negedge clk); ser1Flags = 7'h02;
    @(negedge clk); ser1Flags = '0; ser1En = 1'b0;
    readReg(v);
    chk("R8 latched bit hidden", v, 16'h0000);
    ser1En = 1'b1;
    readReg(v);
    chk("R8 latched bit returns", v, 16'h0200);
    ack(3'd3);
    readReg(v);
    chk("R8 cleared", v, 16'h0000);
  endtask

  task automatic tExt(input logic [4:0] pat);
    logic [15:0] v;
    @(negedge clk); extPin = pat;
    readReg(v);
    chk("R9 sync latency", v, 16'h0000);
    readReg(v);
    chk("R9 pin level", v, {7'd0, pat, 4'd0});
    @(negedge clk); extPin = '0;
    readReg(v);
    readReg(v);
    chk("R9 no latch", v, 16'h0000);
  endtask

  task automatic tHold();
    logic [15:0] v;
    @(negedge clk); tmrReq = 1'b1;
    @(negedge clk); tmrReq = 1'b0;
    readReg(v);
    chk("R10 capture", v, 16'h0001);
    ack(3'd0);
    repeat (2) @(negedge clk);
    chk("R10 hold without read", rdData, 16'h0001);
    readReg(v);
    chk("R10 new capture", v, 16'h0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tTimer();
    tDmaAck();
    tBadSel();
    tRace();
    tSerial();
    tSerGate();
    tExt(5'b10110);
    tExt(5'b01001);
    tHold();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule